// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker for an SD Host Controller

This block runs the descriptor-driven DMA of an SD-style host controller. Software places a chain of 8-byte descriptors in system memory and pulses `start` with the address of the first one. The engine reads each descriptor as two 32-bit words through a request/acknowledge read port and rejects any descriptor whose valid flag is clear. A transfer descriptor is cut into data-move requests, each one an address, a byte count and a direction, at the block-size boundaries. These requests go to an external data mover over a valid/ready port. The engine waits for the mover's `done` pulse before it issues the next request or fetches the next descriptor.

A block that is partly filled at the end of one descriptor stays open. The next transfer descriptor keeps filling it. When block counting is on, every completed block lowers the count. The walk ends when the count reaches zero or when a descriptor carries the end flag. At that point the engine compares the two stop causes and any bytes left over, and reports a length mismatch if they disagree. A descriptor that carries the interrupt flag halts the walk. The walk continues only after a continue request that arrives while 32-bit descriptor mode is selected. A 16-bit status word holds the result, and two interrupt lines are formed from sticky status bits and their signal enables.

Top module: `sgdma_engine`

## Requirements
- R1: A descriptor at pointer P is read as word P (byte 0 = attribute, bits 31:16 = length) then word P+4 (address, bits 1:0 forced to 0). Attribute bits: 0 valid, 1 end, 2 interrupt, 5:4 action (2'b10 transfer, 2'b11 link, other values no data).
- R2: A length field of 0 is taken as 65536 bytes.
- R3: A transfer descriptor issues move requests whose byte count never crosses a `blkSize` boundary (`blkSize` nonzero). A partly filled block carries over into the next descriptor. `mvDirRead` follows `dirRead`.
- R4: After a transfer or no-data descriptor the pointer advances by 8. After a link descriptor it takes the descriptor's address.
- R5: With `blkCntEn` set, the count loaded at start drops by one per completed block, and no further data moves once it is zero.
- R6: The walk ends when (`blkCntEn` and count is 0) or the end flag is set. Status bit 10 (final) is then set and `busy` falls.
- R7: A descriptor with the valid bit clear stops the walk with no data move. It sets status bits 1:0 to 1. If `errStatEn` is set it sets the sticky error status; `errIrq` = `errSigEn` AND that status.
- R8: At the end of the walk a mismatch is flagged in three cases: bytes remain in the descriptor, the end flag is seen with the count nonzero, or the count is zero without the end flag. A mismatch sets bit 2, sets bits 1:0 to 3, and sets the error status if it is enabled.
- R9: Each accepted start clears status bits 10 and 2.
- R10: A descriptor with the interrupt flag that does not end the walk sets status bit 8. If `dmaStatEn` is set it sets the sticky DMA status (`dmaIrq` = `dmaSigEn` AND it), and the engine pauses. It resumes only on `contReq` while paused with `adma32Mode` high.
- R11: `irqAck` clears status bit 8, the error status and the DMA status.
- R12: After reset the status word is 0, and `busy`, `paused`, `memRdReq`, `mvValid`, `errIrq` and `dmaIrq` are all low.
- R13: A read request and a move request are each held until they are acknowledged, and the next fetch starts only after the mover's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk at `tableBase` (ignored while busy) |
| tableBase | input | 32 | Address of the first descriptor |
| blkSize | input | BLK_W | Block size in bytes |
| blkCountIn | input | CNT_W | Block count loaded on start |
| blkCntEn | input | 1 | Enables block counting |
| dirRead | input | 1 | Transfer direction, 1 = card to memory |
| adma32Mode | input | 1 | 32-bit descriptor mode selected |
| contReq | input | 1 | Software continue request |
| irqAck | input | 1 | Clears interrupt status bits |
| errStatEn | input | 1 | Error status enable |
| errSigEn | input | 1 | Error interrupt signal enable |
| dmaStatEn | input | 1 | DMA status enable |
| dmaSigEn | input | 1 | DMA interrupt signal enable |
| memRdReq | output | 1 | Descriptor word read request |
| memRdAddr | output | 32 | Descriptor word address |
| memRdAck | input | 1 | Read acknowledge, data valid |
| memRdData | input | 32 | Read data, little-endian word |
| mvValid | output | 1 | Move request valid |
| mvReady | input | 1 | Mover accepts the request |
| mvAddr | output | 32 | Move memory address |
| mvBytes | output | 17 | Move byte count |
| mvDirRead | output | 1 | Move direction |
| mvDone | input | 1 | Mover finished the last request |
| statusWord | output | 16 | Bits 1:0 error state, 2 mismatch, 8 interrupt, 10 final |
| errIrq | output | 1 | Error interrupt |
| dmaIrq | output | 1 | DMA interrupt |
| busy | output | 1 | Walk in progress or paused |
| paused | output | 1 | Halted at an interrupt descriptor |

## Verification
The hardest cases to reach are the three mismatch endings and a block that spans two descriptors. Each one needs a descriptor table in which the lengths, the block size and the loaded count disagree in one specific way. The bench memory model is rewritten before each scenario with such a table, and every request the mover receives is logged so that the exact cut points can be compared. The pause is held open deliberately: an acknowledge and a continue request sent with the wrong mode are applied there, and the bench confirms that no new move is issued before the valid continue request.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int DESC_BYTES = 8;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 16;

  localparam logic [1:0] ACT_XFER = 2'b10;
  localparam logic [1:0] ACT_LINK = 2'b11;

  localparam logic [1:0] ERRST_STOP  = 2'd0;
  localparam logic [1:0] ERRST_FETCH = 2'd1;
  localparam logic [1:0] ERRST_XFER  = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_CHECKV, ST_EVAL,
    ST_MOVE_REQ, ST_MOVE_WAIT, ST_STEP, ST_CHECK, ST_PAUSED
  } walkState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadStart;
    logic latchW0;
    logic latchW1;
    logic chunkDone;
    logic ptrStep;
    logic ptrLink;
    logic markInvalid;
    logic markMismatch;
    logic markFinal;
    logic markIntr;
  } strobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic valid;
    logic isLink;
    logic intAttr;
    logic moreData;
    logic finish;
    logic mismatch;
  } flags_t;

endpackage

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    contReq,
  input  logic    adma32Mode,
  input  logic    memRdAck,
  input  logic    mvReady,
  input  logic    mvDone,
  input  flags_t  flg,
  output strobe_t stb,
  output logic    memRdReq,
  output logic    memRdSel,
  output logic    mvValid,
  output logic    busy,
  output logic    paused
);

  walkState_t st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext   = st;
    stb      = '0;
    memRdReq = 1'b0;
    memRdSel = 1'b0;
    mvValid  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          stb.loadStart = 1'b1;
          stNext        = ST_FETCH0;
        end
      end
      ST_FETCH0: begin
        memRdReq = 1'b1;
        if (memRdAck) begin
          stb.latchW0 = 1'b1;
          stNext      = ST_FETCH1;
        end
      end
      ST_FETCH1: begin
        memRdReq = 1'b1;
        memRdSel = 1'b1;
        if (memRdAck) begin
          stb.latchW1 = 1'b1;
          stNext      = ST_CHECKV;
        end
      end
      ST_CHECKV: begin
        if (!flg.valid) begin
          stb.markInvalid = 1'b1;
          stNext          = ST_IDLE;
        end else begin
          stNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        stNext = flg.moreData ? ST_MOVE_REQ : ST_STEP;
      end
      ST_MOVE_REQ: begin
        mvValid = 1'b1;
        if (mvReady) stNext = ST_MOVE_WAIT;
      end
      ST_MOVE_WAIT: begin
        if (mvDone) begin
          stb.chunkDone = 1'b1;
          stNext        = ST_EVAL;
        end
      end
      ST_STEP: begin
        if (flg.isLink) stb.ptrLink = 1'b1;
        else            stb.ptrStep = 1'b1;
        stNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (flg.finish) begin
          stb.markMismatch = flg.mismatch;
          stb.markFinal    = 1'b1;
          stNext           = ST_IDLE;
        end else if (flg.intAttr) begin
          stb.markIntr = 1'b1;
          stNext       = ST_PAUSED;
        end else begin
          stNext = ST_FETCH0;
        end
      end
      ST_PAUSED: begin
        if (contReq && adma32Mode) stNext = ST_FETCH0;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign busy   = (st != ST_IDLE);
  assign paused = (st == ST_PAUSED);

  AST_MOVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mvValid && !mvReady) |=> mvValid); // R13
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> memRdReq); // R13
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (paused && !(contReq && adma32Mode)) |=> paused); // R10

endmodule

// File: rtl/sgdma_dpath.sv
module sgdma_dpath
  import sgdma_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              memRdSel,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [BLK_W-1:0]  blkSize,
  input  logic [CNT_W-1:0]  blkCountIn,
  input  logic              blkCntEn,
  input  logic              irqAck,
  input  logic              errStatEn,
  input  logic              errSigEn,
  input  logic              dmaStatEn,
  input  logic              dmaSigEn,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] mvAddr,
  output logic [LEN_W:0]    mvBytes,
  output flags_t            flg,
  output logic [15:0]       statusWord,
  output logic              errIrq,
  output logic              dmaIrq
);

  localparam int XW = LEN_W + 1;

  logic [ADDR_W-1:0] descPtr, dAddr;
  logic [XW-1:0]     remLen;
  logic [BLK_W-1:0]  blkOff;
  logic [CNT_W-1:0]  blkCnt;
  logic              attrValid, attrEnd, attrInt;
  logic [1:0]        attrAct;
  logic [1:0]        errState;
  logic              mmBit, finalBit, intStat, errStat, dmaStat;

  logic [XW-1:0] room, chunk, fill;
  logic          blockFull, isTran, leftover, cntStop;
  logic          unusedRsvd;

  assign unusedRsvd = ^{memRdData[15:8], memRdData[7:6], memRdData[3]};

  // size of the next piece: limited by bytes left and room in the open block
  assign room      = XW'(blkSize) - XW'(blkOff);
  assign chunk     = (remLen < room) ? remLen : room;
  assign fill      = XW'(blkOff) + chunk;
  assign blockFull = (fill == XW'(blkSize));

  assign isTran   = (attrAct == ACT_XFER);
  assign leftover = isTran && (remLen != '0);
  assign cntStop  = blkCntEn && (blkCnt == '0);

  always_comb begin
    flg.valid    = attrValid;
    flg.isLink   = (attrAct == ACT_LINK);
    flg.intAttr  = attrInt;
    flg.moreData = leftover && !cntStop;
    flg.finish   = cntStop || attrEnd;
    flg.mismatch = leftover
                || (attrEnd && blkCntEn && (blkCnt != '0))
                || (cntStop && !attrEnd);
  end

  assign memRdAddr = descPtr + (memRdSel ? ADDR_W'(4) : ADDR_W'(0));
  assign mvAddr    = dAddr;
  assign mvBytes   = chunk;

  // descriptor and transfer progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr   <= '0;
      dAddr     <= '0;
      remLen    <= '0;
      blkOff    <= '0;
      blkCnt    <= '0;
      attrValid <= 1'b0;
      attrEnd   <= 1'b0;
      attrInt   <= 1'b0;
      attrAct   <= 2'b00;
    end else begin
      if (stb.loadStart) begin
        descPtr <= tableBase;
        blkOff  <= '0;
        blkCnt  <= blkCountIn;
      end
      if (stb.latchW0) begin
        attrValid <= memRdData[0];
        attrEnd   <= memRdData[1];
        attrInt   <= memRdData[2];
        attrAct   <= memRdData[5:4];
        remLen    <= (memRdData[31:16] == '0) ? XW'(1) << LEN_W
                                              : XW'(memRdData[31:16]);
      end
      if (stb.latchW1) dAddr <= {memRdData[31:2], 2'b00};
      if (stb.chunkDone) begin
        dAddr  <= dAddr + ADDR_W'(chunk);
        remLen <= remLen - chunk;
        if (blockFull) begin
          blkOff <= '0;
          if (blkCntEn && (blkCnt != '0)) blkCnt <= blkCnt - 1'b1;
        end else begin
          blkOff <= BLK_W'(fill);
        end
      end
      if (stb.ptrStep) descPtr <= descPtr + ADDR_W'(DESC_BYTES);
      if (stb.ptrLink) descPtr <= dAddr;
    end
  end

  // status word and interrupt sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errState <= ERRST_STOP;
      mmBit    <= 1'b0;
      finalBit <= 1'b0;
      intStat  <= 1'b0;
      errStat  <= 1'b0;
      dmaStat  <= 1'b0;
    end else begin
      if (irqAck) begin
        intStat <= 1'b0;
        errStat <= 1'b0;
        dmaStat <= 1'b0;
      end
      if (stb.loadStart) begin
        finalBit <= 1'b0;
        mmBit    <= 1'b0;
      end
      if (stb.markInvalid) begin
        errState <= ERRST_FETCH;
        if (errStatEn) errStat <= 1'b1;
      end
      if (stb.markMismatch) begin
        mmBit    <= 1'b1;
        errState <= ERRST_XFER;
        if (errStatEn) errStat <= 1'b1;
      end
      if (stb.markFinal) finalBit <= 1'b1;
      if (stb.markIntr) begin
        intStat <= 1'b1;
        if (dmaStatEn) dmaStat <= 1'b1;
      end
    end
  end

  assign statusWord = {5'b0, finalBit, 1'b0, intStat, 5'b0, mmBit, errState};
  assign errIrq     = errSigEn && errStat;
  assign dmaIrq     = dmaSigEn && dmaStat;

  AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flg.moreData && blkSize != '0) |-> (chunk != '0)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStart |=> (!statusWord[10] && !statusWord[2])); // R9
  AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (blkCnt == '0 && !stb.loadStart) |=> (blkCnt == '0)); // R5
  AST_LINK_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrLink |=> (descPtr[1:0] == 2'b00)); // R1

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [BLK_W-1:0]  blkSize,
  input  logic [CNT_W-1:0]  blkCountIn,
  input  logic              blkCntEn,
  input  logic              dirRead,
  input  logic              adma32Mode,
  input  logic              contReq,
  input  logic              irqAck,
  input  logic              errStatEn,
  input  logic              errSigEn,
  input  logic              dmaStatEn,
  input  logic              dmaSigEn,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [31:0]       memRdData,
  output logic              mvValid,
  input  logic              mvReady,
  output logic [ADDR_W-1:0] mvAddr,
  output logic [LEN_W:0]    mvBytes,
  output logic              mvDirRead,
  input  logic              mvDone,
  output logic [15:0]       statusWord,
  output logic              errIrq,
  output logic              dmaIrq,
  output logic              busy,
  output logic              paused
);

  strobe_t stb;
  flags_t  flg;
  logic    memRdSel;

  sgdma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .contReq(contReq),
    .adma32Mode(adma32Mode), .memRdAck(memRdAck), .mvReady(mvReady),
    .mvDone(mvDone), .flg(flg), .stb(stb), .memRdReq(memRdReq),
    .memRdSel(memRdSel), .mvValid(mvValid), .busy(busy), .paused(paused)
  );

  sgdma_dpath #(.BLK_W(BLK_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdSel(memRdSel),
    .tableBase(tableBase), .blkSize(blkSize), .blkCountIn(blkCountIn),
    .blkCntEn(blkCntEn), .irqAck(irqAck), .errStatEn(errStatEn),
    .errSigEn(errSigEn), .dmaStatEn(dmaStatEn), .dmaSigEn(dmaSigEn),
    .memRdData(memRdData), .memRdAddr(memRdAddr), .mvAddr(mvAddr),
    .mvBytes(mvBytes), .flg(flg), .statusWord(statusWord),
    .errIrq(errIrq), .dmaIrq(dmaIrq)
  );

  assign mvDirRead = dirRead;

endmodule

// File: tb/tb_sgdma_engine.sv
`timescale 1ns/1ps
module tb_sgdma_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tableBase = '0;
  logic [11:0] blkSize = 12'd512;
  logic [15:0] blkCountIn = '0;
  logic        blkCntEn = 1'b0, dirRead = 1'b0, adma32Mode = 1'b1;
  logic        contReq = 1'b0, irqAck = 1'b0;
  logic        errStatEn = 1'b0, errSigEn = 1'b0, dmaStatEn = 1'b0, dmaSigEn = 1'b0;
  logic        memRdReq, memRdAck = 1'b0;
  logic [31:0] memRdAddr, memRdData = '0;
  logic        mvValid, mvReady = 1'b0, mvDone = 1'b0, mvDirRead;
  logic [31:0] mvAddr;
  logic [16:0] mvBytes;
  logic [15:0] statusWord;
  logic        errIrq, dmaIrq, busy, paused;

  sgdma_engine dut (
    .clk(clk), .rstN(rstN), .start(start), .tableBase(tableBase),
    .blkSize(blkSize), .blkCountIn(blkCountIn), .blkCntEn(blkCntEn),
    .dirRead(dirRead), .adma32Mode(adma32Mode), .contReq(contReq),
    .irqAck(irqAck), .errStatEn(errStatEn), .errSigEn(errSigEn),
    .dmaStatEn(dmaStatEn), .dmaSigEn(dmaSigEn), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .mvValid(mvValid), .mvReady(mvReady), .mvAddr(mvAddr),
    .mvBytes(mvBytes), .mvDirRead(mvDirRead), .mvDone(mvDone),
    .statusWord(statusWord), .errIrq(errIrq), .dmaIrq(dmaIrq),
    .busy(busy), .paused(paused)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic [31:0] mem [0:63];
  logic [31:0] logAddr [0:63];
  logic [16:0] logBytes [0:63];
  logic        logDir [0:63];
  int          logCnt = 0;
  longint      logSum = 0;
  logic [31:0] rdLog [0:15];
  int          rdCnt = 0;
  int          mvTimer = 0;

  // memory and data-mover models, driven away from the active edge
  always @(negedge clk) begin
    if (memRdReq && !memRdAck) begin
      memRdData = mem[memRdAddr[7:2]];
      memRdAck  = 1'b1;
      if (rdCnt < 16) rdLog[rdCnt] = memRdAddr;
      rdCnt++;
    end else begin
      memRdAck = 1'b0;
    end
    mvDone = 1'b0;
    if (mvReady) begin
      mvReady = 1'b0;
      mvTimer = 2;
    end else if (mvTimer != 0) begin
      mvTimer--;
      if (mvTimer == 0) mvDone = 1'b1;
    end else if (mvValid) begin
      if (logCnt < 64) begin
        logAddr[logCnt]  = mvAddr;
        logBytes[logCnt] = mvBytes;
        logDir[logCnt]   = mvDirRead;
      end
      logCnt++;
      logSum += mvBytes;
      mvReady = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    logCnt = 0;
    logSum = 0;
    rdCnt  = 0;
  endtask

  task automatic putDesc(input int byteAddr, input logic [7:0] attr,
                         input logic [15:0] len, input logic [31:0] addr);
    mem[byteAddr >> 2]       = {len, 8'h00, attr};
    mem[(byteAddr >> 2) + 1] = addr;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitStop();
    int n = 0;
    while (busy && !paused && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk("WATCHDOG walk stuck", 32'd1, 32'd0);
  endtask

  task automatic pulseAck();
    @(negedge clk) irqAck = 1'b1;
    @(negedge clk) irqAck = 1'b0;
  endtask

  task automatic tReset();
    chk("R12 status after reset", {16'b0, statusWord}, 32'h0);
    chk("R12 busy after reset", {31'b0, busy}, 32'd0);
    chk("R12 paused after reset", {31'b0, paused}, 32'd0);
    chk("R12 memRdReq after reset", {31'b0, memRdReq}, 32'd0);
    chk("R12 mvValid after reset", {31'b0, mvValid}, 32'd0);
    chk("R12 irqs after reset", {30'b0, errIrq, dmaIrq}, 32'd0);
  endtask

  task automatic tBasic();
    clearMem();
    putDesc(0, 8'h23, 16'd1024, 32'h0000_1003);
    blkSize = 12'd512; blkCntEn = 1'b0; dirRead = 1'b1;
    pulseStart(); waitStop();
    chk("R1 fetch word0 addr", rdLog[0], 32'h0);
    chk("R1 fetch word1 addr", rdLog[1], 32'h4);
    chk("R3 move count", logCnt, 2);
    chk("R1 address low bits forced", logAddr[0], 32'h1000);
    chk("R3 first piece bytes", {15'b0, logBytes[0]}, 32'd512);
    chk("R3 second piece addr", logAddr[1], 32'h1200);
    chk("R3 direction forwarded", {31'b0, logDir[1]}, 32'd1);
    chk("R6 final bit", {16'b0, statusWord}, 32'h400);
    chk("R6 busy low at end", {31'b0, busy}, 32'd0);
  endtask

  task automatic tPartial();
    clearMem();
    putDesc(0, 8'h21, 16'd300, 32'h0000_2000);
    putDesc(8, 8'h23, 16'd724, 32'h0000_3000);
    blkSize = 12'd512; blkCntEn = 1'b1; blkCountIn = 16'd2; dirRead = 1'b0;
    pulseStart(); waitStop();
    chk("R3 partial move count", logCnt, 3);
    chk("R3 piece0 bytes", {15'b0, logBytes[0]}, 32'd300);
    chk("R3 carried block piece bytes", {15'b0, logBytes[1]}, 32'd212);
    chk("R3 carried block piece addr", logAddr[1], 32'h3000);
    chk("R3 piece2 addr", logAddr[2], 32'h30D4);
    chk("R3 piece2 bytes", {15'b0, logBytes[2]}, 32'd512);
    chk("R3 direction forwarded", {31'b0, logDir[0]}, 32'd0);
    chk("R5 count reaches zero with end: no mismatch", {16'b0, statusWord}, 32'h400);
  endtask

  task automatic tLink();
    clearMem();
    putDesc(0, 8'h31, 16'd0, 32'h0000_0042);
    putDesc(64, 8'h01, 16'd4, 32'h0000_9000);
    putDesc(72, 8'h23, 16'd16, 32'h0000_5000);
    blkSize = 12'd16; blkCntEn = 1'b0;
    pulseStart(); waitStop();
    chk("R4 fetch count", rdCnt, 6);
    chk("R4 link target fetch", rdLog[2], 32'h40);
    chk("R4 step after no-data descriptor", rdLog[4], 32'h48);
    chk("R4 only transfer moves", logCnt, 1);
    chk("R4 moved addr", logAddr[0], 32'h5000);
    chk("R6 final after link chain", {16'b0, statusWord}, 32'h400);
  endtask

  task automatic tMaxLen();
    clearMem();
    putDesc(0, 8'h23, 16'd0, 32'h0001_0000);
    blkSize = 12'd2048; blkCntEn = 1'b0;
    pulseStart(); waitStop();
    chk("R2 zero length piece count", logCnt, 32);
    chk("R2 zero length total bytes", logSum[31:0], 32'd65536);
    chk("R2 last piece addr", logAddr[31], 32'h0001_F800);
    chk("R2 no mismatch", {16'b0, statusWord}, 32'h400);
  endtask

  task automatic tPause();
    clearMem();
    putDesc(0, 8'h25, 16'd32, 32'h0000_6000);
    putDesc(8, 8'h23, 16'd32, 32'h0000_7000);
    blkSize = 12'd32; blkCntEn = 1'b0; dmaStatEn = 1'b1; dmaSigEn = 1'b1;
    adma32Mode = 1'b1;
    pulseStart(); waitStop();
    chk("R10 paused", {31'b0, paused}, 32'd1);
    chk("R10 interrupt bit set", {16'b0, statusWord}, 32'h100);
    chk("R10 dma irq", {31'b0, dmaIrq}, 32'd1);
    pulseAck();
    chk("R11 ack clears bit8", {16'b0, statusWord}, 32'h0);
    chk("R11 ack clears dma irq", {31'b0, dmaIrq}, 32'd0);
    adma32Mode = 1'b0;
    @(negedge clk) contReq = 1'b1;
    @(negedge clk) contReq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 continue ignored in other mode", {31'b0, paused}, 32'd1);
    chk("R10 no move while paused", logCnt, 1);
    adma32Mode = 1'b1;
    @(negedge clk) contReq = 1'b1;
    @(negedge clk) contReq = 1'b0;
    waitStop();
    chk("R10 resumed move", logCnt, 2);
    chk("R10 resumed addr", logAddr[1], 32'h7000);
    chk("R10 final after resume", {16'b0, statusWord}, 32'h400);
    dmaStatEn = 1'b0; dmaSigEn = 1'b0;
  endtask

  task automatic tInvalid();
    clearMem();
    putDesc(0, 8'h22, 16'd64, 32'h0000_4000);
    errStatEn = 1'b1; errSigEn = 1'b1;
    pulseStart(); waitStop();
    chk("R7 invalid stops walk", {31'b0, busy}, 32'd0);
    chk("R7 invalid status", {16'b0, statusWord}, 32'h001);
    chk("R7 no move on invalid", logCnt, 0);
    chk("R7 error irq", {31'b0, errIrq}, 32'd1);
    pulseAck();
    chk("R11 ack clears error irq", {31'b0, errIrq}, 32'd0);
    errStatEn = 1'b0;
    pulseStart(); waitStop();
    chk("R7 status disabled: no irq", {31'b0, errIrq}, 32'd0);
    errStatEn = 1'b1;
  endtask

  task automatic tMismatch(input string tag, input logic [7:0] attr,
                           input logic [15:0] cnt, input int expMoves,
                           input int expReads);
    clearMem();
    putDesc(0, attr, 16'd128, 32'h0000_8000);
    putDesc(8, 8'h23, 16'd64, 32'h0000_A000);
    blkSize = 12'd64; blkCntEn = 1'b1; blkCountIn = cnt;
    pulseAck();
    pulseStart();
    chk({"R9 start clears final and mismatch ", tag},
        {16'b0, statusWord & 16'h0404}, 32'h0);
    waitStop();
    chk({"R8 status ", tag}, {16'b0, statusWord}, 32'h407);
    chk({"R8 error irq ", tag}, {31'b0, errIrq}, 32'd1);
    chk({"R5 moves ", tag}, logCnt, expMoves);
    chk({"R13 fetches ", tag}, rdCnt, expReads);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tPartial();
    tLink();
    tMaxLen();
    tPause();
    tInvalid();
    tMismatch("bytes left", 8'h23, 16'd1, 1, 2);
    tMismatch("end with count", 8'h23, 16'd3, 2, 2);
    tMismatch("count without end", 8'h21, 16'd2, 2, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL WATCHDOG run did not finish actual=0x1 expected=0x0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule